// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory with Background Scrub

This block is a small word-addressed memory in which every 8-bit data word is stored together with four Hamming check bits and one overall parity bit, 13 bits in all. Host writes are encoded on the way in. Host reads are decoded on the way out, with one cycle of latency. Each read is reported as clean, corrected or uncorrectable. A single flipped bit anywhere in the stored word is repaired in the returned data. A double flip is flagged, and the stored data bits are returned unchanged.

In every cycle where the host issues no request and no fault is being injected, a scrubber decodes one location. If that location holds a correctable error, the scrubber writes the repaired word back. It then moves to the next address, in ascending order, and wraps at the top. Because of this, isolated flips do not sit in the array long enough for a second flip to land in the same word. The array is built from internal registers. A fault-injection port XORs a mask into any stored word so that errors can be created for testing.

Top module: `ecc_scrub_mem`

## Requirements
- R1: A host write stores data in bits [7:0], check bits in [11:8] and even overall parity in bit [12]. The check bits are: bit 8 = d0^d1^d3^d4^d6, bit 9 = d0^d2^d3^d5^d6, bit 10 = d1^d2^d3^d7, bit 11 = d4^d5^d6^d7. Every one of the 256 data values reads back unchanged and clean.
- R2: A read issued at one rising edge presents rvalid_o, rdata_o, corr_o and uncorr_o after the next rising edge. A write cycle leaves rvalid_o low.
- R3: When exactly one of bits [11:0] of a stored word is flipped, the read returns the original data with corr_o=1 and uncorr_o=0.
- R4: When only the parity bit [12] is flipped, the read returns the original data with corr_o=1 and uncorr_o=0.
- R5: When any two of the 13 bits are flipped, the read sets uncorr_o=1 and corr_o=0, and rdata_o equals the stored bits [7:0] with no correction applied.
- R6: corr_o and uncorr_o are never high together, and both are low whenever rvalid_o is low.
- R7: After reset, every word holds zero, all outputs are low, and a read of any address returns 0 as clean.
- R8: The scrubber does nothing in a cycle with req_i or inj_en_i high: it neither advances its address nor writes.
- R9: In each cycle with neither req_i nor inj_en_i high, the scrubber decodes one address, moving upward and wrapping. It writes back the repaired word when it finds a correctable error. After 2^ADDR_W idle cycles, every word that held a single flip reads back clean.
- R10: The scrubber leaves uncorrectable words as they are, so they still read back as uncorrectable with the same raw data.
- R11: A word with odd overall parity whose syndrome is non-zero but matches no column of the check matrix is reported as uncorrectable, and its data is not altered.
- R12: inj_en_i XORs inj_mask_i into the word at inj_addr_i. A host write to the same address in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host write when high, read when low |
| addr_i | input | ADDR_W | Host word address |
| wdata_i | input | 8 | Host write data |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | 8 | Read data, corrected where possible |
| corr_o | output | 1 | Read found and corrected a single-bit error |
| uncorr_o | output | 1 | Read found an uncorrectable error |
| inj_en_i | input | 1 | Fault-injection strobe |
| inj_addr_i | input | ADDR_W | Word to corrupt |
| inj_mask_i | input | 13 | Bits to invert in the stored word |

## Verification
The bench injects every single-bit position, including each check bit and the parity bit alone. A decoder with a wrong column map would then miscorrect a data bit, and one that ignores the parity-only case would report a clean word as uncorrectable. All 78 two-bit patterns are tried, so a decoder that trusts a non-zero syndrome without looking at parity would flip a third bit and claim success. Check-bit triples with unmatched syndromes catch a decoder that defaults to correcting. Scrubbing is tested twice: while a host burst keeps it paused, where a scrubber that steals cycles would clear the error early, and after an idle window, where one that fails to write back, or that rewrites double-error words, leaves the wrong flags behind.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int WORD_W = DATA_W + CHK_W + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {CLS_CLEAN, CLS_FIXED, CLS_BAD} cls_e;

  function automatic logic [CHK_W-1:0] chk_bits(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c[0] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c[1] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[2] = d[1] ^ d[2] ^ d[3] ^ d[7];
    c[3] = d[4] ^ d[5] ^ d[6] ^ d[7];
    return c;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output word_t             word_o
);
  logic [CHK_W-1:0] chk;
  assign chk    = chk_bits(data_i);
  assign word_o = {^{chk, data_i}, chk, data_i};
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_pkg::*;
(
  input  word_t             word_i,
  output logic [DATA_W-1:0] data_o,
  output cls_e              cls_o
);
  localparam int COLS = DATA_W + CHK_W;

  logic [CHK_W-1:0] syn;
  logic             perr;
  logic [COLS-1:0]  hit;
  logic             match;
  logic             fix;

  assign syn  = chk_bits(word_i[DATA_W-1:0]) ^ word_i[COLS-1:DATA_W];
  assign perr = ^word_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
    assign hit[i] = (syn == chk_bits(DATA_W'(1) << i));
  end
  for (genvar i = 0; i < CHK_W; i++) begin : g_ccol
    assign hit[DATA_W+i] = (syn == (CHK_W'(1) << i));
  end

  assign match  = |hit;
  // flip only on odd parity with a matching column; zero syndrome never matches
  assign fix    = perr && match;
  assign data_o = word_i[DATA_W-1:0] ^ (fix ? hit[DATA_W-1:0] : '0);

  always_comb begin
    if (!perr && syn == '0)            cls_o = CLS_CLEAN;
    else if (perr && (syn == '0 || match)) cls_o = CLS_FIXED;
    else                               cls_o = CLS_BAD;
  end
endmodule

// File: rtl/ecc_array.sv
module ecc_array
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  word_t             wword_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  word_t             inj_mask_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output word_t             rword_a_o,
  output word_t             rword_b_o
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_i && waddr_i == ADDR_W'(i))            mem_q[i] <= wword_i;
        else if (inj_en_i && inj_addr_i == ADDR_W'(i)) mem_q[i] <= mem_q[i] ^ inj_mask_i;
      end
    end
  end

  assign rword_a_o = mem_q[raddr_a_i];
  assign rword_b_o = mem_q[raddr_b_i];

  // R1: every written word carries even overall parity
  a_r1_even_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (^mem_q[$past(waddr_i)]) == 1'b0);
endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              rvalid_o,
  output logic [7:0]        rdata_o,
  output logic              corr_o,
  output logic              uncorr_o,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [12:0]       inj_mask_i
);
  word_t             host_word, host_enc, scrub_word, scrub_enc, arr_wword;
  logic [DATA_W-1:0] host_data, scrub_data;
  cls_e              host_cls, scrub_cls;
  logic [ADDR_W-1:0] scrub_addr_q, arr_waddr;
  logic              scrub_go, scrub_wr, host_wr, host_rd, arr_we;

  assign host_wr  = req_i && we_i;
  assign host_rd  = req_i && !we_i;
  assign scrub_go = !req_i && !inj_en_i;
  assign scrub_wr = scrub_go && scrub_cls == CLS_FIXED;

  assign arr_we    = host_wr || scrub_wr;
  assign arr_waddr = host_wr ? addr_i : scrub_addr_q;
  assign arr_wword = host_wr ? host_enc : scrub_enc;

  ecc_enc u_enc_host  (.data_i(wdata_i),    .word_o(host_enc));
  ecc_enc u_enc_scrub (.data_i(scrub_data), .word_o(scrub_enc));

  ecc_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (arr_we),
    .waddr_i    (arr_waddr),
    .wword_i    (arr_wword),
    .inj_en_i   (inj_en_i),
    .inj_addr_i (inj_addr_i),
    .inj_mask_i (inj_mask_i),
    .raddr_a_i  (addr_i),
    .raddr_b_i  (scrub_addr_q),
    .rword_a_o  (host_word),
    .rword_b_o  (scrub_word)
  );

  ecc_dec u_dec_host  (.word_i(host_word),  .data_o(host_data),  .cls_o(host_cls));
  ecc_dec u_dec_scrub (.word_i(scrub_word), .data_o(scrub_data), .cls_o(scrub_cls));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scrub_addr_q <= '0;
    else if (scrub_go) scrub_addr_q <= scrub_addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      corr_o   <= 1'b0;
      uncorr_o <= 1'b0;
    end else begin
      rvalid_o <= host_rd;
      corr_o   <= host_rd && host_cls == CLS_FIXED;
      uncorr_o <= host_rd && host_cls == CLS_BAD;
      if (host_rd) rdata_o <= host_data;
    end
  end

  a_r2_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd |=> rvalid_o);
  a_r2_write_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr |=> !rvalid_o);
  a_r6_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_o && uncorr_o));
  a_r6_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> !corr_o && !uncorr_o);
  a_r8_scrub_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i || inj_en_i) |=> $stable(scrub_addr_q));
  a_r9_scrub_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrub_go |=> scrub_addr_q == ADDR_W'($past(scrub_addr_q) + 1'b1));
endmodule

// File: tb/ecc_scrub_mem_test.sv
module ecc_scrub_mem_test;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0, inj_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0, inj_addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic [12:0]       inj_mask_i = '0;
  logic              rvalid_o, corr_o, uncorr_o;
  logic [7:0]        rdata_o;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_scrub_mem #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .corr_o(corr_o),
    .uncorr_o(uncorr_o), .inj_en_i(inj_en_i), .inj_addr_i(inj_addr_i),
    .inj_mask_i(inj_mask_i)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; inj_en_i = 0;
    @(negedge clk);
  endtask

  task automatic inj(input logic [ADDR_W-1:0] a, input logic [12:0] m);
    req_i = 0; inj_en_i = 1; inj_addr_i = a; inj_mask_i = m;
    @(negedge clk);
    inj_en_i = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    req_i = 1; we_i = 0; addr_i = a; inj_en_i = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_i = 0; inj_en_i = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] d, input logic c, input logic u);
    check(tag, {1'b0, rvalid_o, corr_o, uncorr_o, rdata_o}, {1'b0, 1'b1, c, u, d});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset outputs", {8'h0, rvalid_o, corr_o, uncorr_o, 1'b0}, 12'h0);
    rst_ni = 1;
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      rd(ADDR_W'(a));
      expect_rd("R7 zero after reset", 8'h00, 0, 0);
    end

    // R1/R2: every data value round trips clean
    for (int d = 0; d < 256; d++) begin
      wr(ADDR_W'(d), 8'(d));
      check("R2 write gives no rvalid", {11'h0, rvalid_o}, 12'h0);
      rd(ADDR_W'(d));
      expect_rd("R1 clean round trip", 8'(d), 0, 0);
    end

    // R3: single flips in data and check bits
    for (int k = 0; k < 16; k++) begin
      for (int b = 0; b < 12; b++) begin
        wr(ADDR_W'(k), 8'(k * 37 + 11));
        inj(ADDR_W'(k), 13'(1) << b);
        rd(ADDR_W'(k));
        expect_rd("R3 single flip corrected", 8'(k * 37 + 11), 1, 0);
      end
      // R4: parity bit alone
      wr(ADDR_W'(k), 8'(k * 19 + 5));
      inj(ADDR_W'(k), 13'h1000);
      rd(ADDR_W'(k));
      expect_rd("R4 parity-only flip", 8'(k * 19 + 5), 1, 0);
    end

    // R5: every pair of flipped bits
    for (int i = 0; i < 13; i++) begin
      for (int j = i + 1; j < 13; j++) begin
        logic [12:0] m;
        logic [7:0]  d;
        m = (13'(1) << i) | (13'(1) << j);
        d = 8'(i * 29 + j * 7 + 3);
        wr(ADDR_W'(i + j), d);
        inj(ADDR_W'(i + j), m);
        rd(ADDR_W'(i + j));
        expect_rd("R5 double flip detected", d ^ m[7:0], 0, 1);
      end
    end

    // R11: odd-parity patterns with unmatched syndromes 13 and 14
    wr(4'd9, 8'hA5); inj(4'd9, 13'h0D00); rd(4'd9);
    expect_rd("R11 unmatched syndrome 13", 8'hA5, 0, 1);
    wr(4'd9, 8'h3E); inj(4'd9, 13'h0E00); rd(4'd9);
    expect_rd("R11 unmatched syndrome 14", 8'h3E, 0, 1);

    // R12: host write overrides injection in the same cycle
    req_i = 1; we_i = 1; addr_i = 4'd7; wdata_i = 8'h6B;
    inj_en_i = 1; inj_addr_i = 4'd7; inj_mask_i = 13'h0001;
    @(negedge clk);
    inj_en_i = 0;
    rd(4'd7);
    expect_rd("R12 write beats injection", 8'h6B, 0, 0);

    // R8: host burst holds the scrubber off
    wr(4'd5, 8'h3C);
    inj(4'd5, 13'h0004);
    for (int n = 0; n < 3 * DEPTH; n++) rd(4'd6);
    rd(4'd5);
    expect_rd("R8 no scrub during host burst", 8'h3C, 1, 0);

    // R9/R10: idle scrub repairs singles, leaves doubles
    for (int a = 0; a < DEPTH; a++) wr(ADDR_W'(a), 8'(a * 11 + 7));
    for (int a = 0; a < DEPTH; a++)
      inj(ADDR_W'(a), (a == 3) ? 13'h0003 : (13'(1) << (a % 13)));
    idle(DEPTH + 2);
    for (int a = 0; a < DEPTH; a++) begin
      rd(ADDR_W'(a));
      if (a == 3) expect_rd("R10 double survives scrub", 8'(a * 11 + 7) ^ 8'h03, 0, 1);
      else        expect_rd("R9 scrub repaired word", 8'(a * 11 + 7), 0, 0);
    end

    // R6: flags drop when no read follows
    idle(1);
    check("R6 flags low without read", {9'h0, rvalid_o, corr_o, uncorr_o}, 12'h0);

    summary();
  end
endmodule